// File: doc/BRIEF.md
# Hybrid Prefix Subtractor for Residue-to-Binary Output

This block forms the last subtraction of a residue-to-binary converter. It is purely combinational: it takes a wide minuend `p_i` of 4N+1 bits and a narrow subtrahend `t_i` of 2N+1 bits. It returns their difference modulo 2^(4N+1) on `s_o`. The difference is built as p plus the one's complement of t plus one, with the carry into bit 0 tied to one.

The second operand of that addition is only variable in its low 2N positions. Its upper 2N+1 positions are constant ones. The low half therefore goes through a parallel-prefix carry network, and a compile-time parameter selects its topology: Brent–Kung, Sklansky or Kogge–Stone. The upper half needs no full adders. Each of its cells reduces to an XNOR for the sum and an OR for the carry, and these cells are chained by ripple. The carry leaving the top cell is dropped.

The surrounding converter guarantees that the subtrahend fits in 2N bits. The top bit of `t_i` sits where the complemented operand is taken to be one, so it never enters the result. The default N = 4 gives a 17-bit datapath.

Top module: `hybrid_sub_adder`

## Requirements
- R1: `s_o` equals (`p_i` − `t_i[2N-1:0]`) modulo 2^(4N+1) for every input pair.
- R2: `s_o[2N-1:0]` equals (`p_i[2N-1:0]` − `t_i[2N-1:0]`) modulo 2^(2N).
- R3: `s_o[4N:2N]` equals `p_i[4N:2N]` minus one when `p_i[2N-1:0]` < `t_i[2N-1:0]`, and equals `p_i[4N:2N]` otherwise, modulo 2^(2N+1).
- R4: With `t_i[2N-1:0]` all zero, `s_o` equals `p_i`, because the forced carry-in of one cancels the all-ones operand.
- R5: `t_i[2N]` has no effect on `s_o`.
- R6: With `p_i` = 0 and `t_i[2N-1:0]` all ones, `s_o` = 2^(4N+1) − 2^(2N) + 1. The borrow then ripples through every upper cell.
- R7: The topology parameter `TOPO` (0 = Brent–Kung, 1 = Sklansky, 2 = Kogge–Stone) changes only the structure, never the value of `s_o`.
- R8: When `p_i[2N-1:0]` equals `t_i[2N-1:0]`, the low 2N bits of `s_o` are zero and the upper bits equal `p_i[4N:2N]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| p_i | input | 4N+1 | Minuend |
| t_i | input | 2N+1 | Subtrahend; only the low 2N bits are used |
| s_o | output | 4N+1 | Difference modulo 2^(4N+1) |

## Verification
The bound checker compares the output against an arithmetic reference whenever the inputs change. It checks the low-half difference, the borrow-driven upper half, the whole modular difference and the identity case with a zero subtrahend. Two behaviours cannot be shown by a single instance under a property, and only the bench's scenarios show them. The first is that all three prefix topologies agree, which needs parallel instances. The second is that the top subtrahend bit is ignored, which needs paired stimuli that differ only in that bit. The full-length borrow ripple from an all-zero minuend is also exercised directly by the bench.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

  typedef enum int {
    TOPO_BK = 0,
    TOPO_SK = 1,
    TOPO_KS = 2
  } topo_e;

  // number of prefix stages for a given topology and width
  function automatic int stage_count(topo_e topo, int width);
    int lv;
    lv = $clog2(width);
    if (topo == TOPO_BK) return (2 * lv) - 1;
    return lv;
  endfunction

endpackage

// File: rtl/hpa_prefix_carry.sv
module hpa_prefix_carry #(
  parameter int             WL   = 8,
  parameter hpa_pkg::topo_e TOPO = hpa_pkg::TOPO_SK
) (
  input  logic [WL-1:0] a_i,
  input  logic [WL-1:0] b_i,
  output logic [WL-1:0] sum_o,
  output logic          cout_o
);
  localparam int LV = $clog2(WL);
  localparam int NS = hpa_pkg::stage_count(TOPO, WL);

  logic [WL-1:0]       prop;
  logic [NS:0][WL-1:0] gs;
  logic [NS:0][WL-1:0] ps;
  logic [WL:0]         carry;

  assign prop  = a_i ^ b_i;
  assign gs[0] = a_i & b_i;
  assign ps[0] = prop;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    for (genvar i = 0; i < WL; i++) begin : g_bit
      if (TOPO == hpa_pkg::TOPO_KS) begin : g_ks
        if (i >= (1 << s)) begin : g_op
          assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-(1<<s)]);
          assign ps[s+1][i] = ps[s][i] & ps[s][i-(1<<s)];
        end else begin : g_pass
          assign gs[s+1][i] = gs[s][i];
          assign ps[s+1][i] = ps[s][i];
        end
      end else if (TOPO == hpa_pkg::TOPO_SK) begin : g_sk
        if (((i >> s) & 1) == 1) begin : g_op
          localparam int J = ((i >> s) << s) - 1;
          assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][J]);
          assign ps[s+1][i] = ps[s][i] & ps[s][J];
        end else begin : g_pass
          assign gs[s+1][i] = gs[s][i];
          assign ps[s+1][i] = ps[s][i];
        end
      end else begin : g_bk
        if (s < LV) begin : g_up
          if (((i + 1) % (2 << s)) == 0) begin : g_op
            assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-(1<<s)]);
            assign ps[s+1][i] = ps[s][i] & ps[s][i-(1<<s)];
          end else begin : g_pass
            assign gs[s+1][i] = gs[s][i];
            assign ps[s+1][i] = ps[s][i];
          end
        end else begin : g_down
          localparam int L = (2 * LV) - 2 - s;
          if ((((i + 1) % (2 << L)) == (1 << L)) && (i >= (2 << L))) begin : g_op
            assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-(1<<L)]);
            assign ps[s+1][i] = ps[s][i] & ps[s][i-(1<<L)];
          end else begin : g_pass
            assign gs[s+1][i] = gs[s][i];
            assign ps[s+1][i] = ps[s][i];
          end
        end
      end
    end
  end

  // carry-in of one folded in: group generate or group propagate
  assign carry[0] = 1'b1;
  for (genvar i = 0; i < WL; i++) begin : g_carry
    assign carry[i+1] = gs[NS][i] | ps[NS][i];
  end

  assign sum_o  = prop ^ carry[WL-1:0];
  assign cout_o = carry[WL];
endmodule

// File: rtl/hpa_const_chain.sv
module hpa_const_chain #(
  parameter int WU = 9
) (
  input  logic [WU-1:0] a_i,
  input  logic          cin_i,
  output logic [WU-1:0] sum_o
);
  logic [WU-1:0] cy;

  assign cy[0] = cin_i;
  for (genvar k = 0; k < WU; k++) begin : g_cell
    assign sum_o[k] = ~(a_i[k] ^ cy[k]);
    if (k < WU - 1) begin : g_link
      assign cy[k+1] = a_i[k] | cy[k];
    end
  end
endmodule

// File: rtl/hybrid_sub_adder.sv
module hybrid_sub_adder #(
  parameter int             N    = 4,
  parameter hpa_pkg::topo_e TOPO = hpa_pkg::TOPO_SK
) (
  input  logic [4*N:0]   p_i,
  input  logic [2*N:0]   t_i,
  output logic [4*N:0]   s_o
);
  localparam int WL = 2 * N;
  localparam int WU = (2 * N) + 1;
  localparam int W  = WL + WU;

  logic [WL-1:0] t_inv;
  logic [WL-1:0] low_sum;
  logic [WU-1:0] up_sum;
  logic          low_cout;

  assign t_inv = ~t_i[WL-1:0];

  hpa_prefix_carry #(.WL(WL), .TOPO(TOPO)) u_low (
    .a_i   (p_i[WL-1:0]),
    .b_i   (t_inv),
    .sum_o (low_sum),
    .cout_o(low_cout)
  );

  hpa_const_chain #(.WU(WU)) u_up (
    .a_i  (p_i[W-1:WL]),
    .cin_i(low_cout),
    .sum_o(up_sum)
  );

  assign s_o = {up_sum, low_sum};
endmodule

// File: rtl/hybrid_sub_adder_chk.sv
module hybrid_sub_adder_chk #(
  parameter int N = 4
) (
  input logic [4*N:0] p_i,
  input logic [2*N:0] t_i,
  input logic [4*N:0] s_o
);
  localparam int WL = 2 * N;
  localparam int WU = (2 * N) + 1;
  localparam int W  = WL + WU;

  logic [W-1:0]  t_ext;
  logic          brw;

  always_comb begin
    t_ext = W'(t_i & {1'b0, {WL{1'b1}}});
    brw   = (p_i[WL-1:0] < t_i[WL-1:0]);
    // R1
    full_diff_chk: assert (s_o == W'(p_i - t_ext));
    // R2
    low_diff_chk: assert (s_o[WL-1:0] == WL'(p_i[WL-1:0] - t_i[WL-1:0]));
    // R3
    hi_borrow_chk: assert (s_o[W-1:WL] == WU'(p_i[W-1:WL] - WU'(brw)));
    // R4
    zero_sub_chk: assert ((t_i[WL-1:0] != '0) || (s_o == p_i));
  end
endmodule

bind hybrid_sub_adder hybrid_sub_adder_chk #(.N(N)) u_chk (
  .p_i(p_i),
  .t_i(t_i),
  .s_o(s_o)
);

// File: tb/sim_hybrid_sub_adder.sv
module sim_hybrid_sub_adder;
  localparam int N  = 4;
  localparam int WL = 2 * N;
  localparam int W  = 4 * N + 1;

  logic clk;
  logic rst_n;
  logic [W-1:0]  p;
  logic [WL:0]   t;
  logic [W-1:0]  s_sk, s_bk, s_ks;
  int checks;
  int failures;
  bit done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hybrid_sub_adder #(.N(N), .TOPO(hpa_pkg::TOPO_SK)) u0 (.p_i(p), .t_i(t), .s_o(s_sk));
  hybrid_sub_adder #(.N(N), .TOPO(hpa_pkg::TOPO_BK)) u1 (.p_i(p), .t_i(t), .s_o(s_bk));
  hybrid_sub_adder #(.N(N), .TOPO(hpa_pkg::TOPO_KS)) u2 (.p_i(p), .t_i(t), .s_o(s_ks));

  function automatic logic [W-1:0] ref_diff(logic [W-1:0] a, logic [WL:0] b);
    return W'(a - W'(b[WL-1:0]));
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [WL:0] b);
    @(negedge clk);
    p = a;
    t = b;
    #1;
  endtask

  // R7: all topologies give the same value as the reference
  task automatic check_all(string req, logic [W-1:0] exp);
    check(req, s_sk, exp);
    check({req, " R7 bk"}, s_bk, exp);
    check({req, " R7 ks"}, s_ks, exp);
  endtask

  task automatic t_reset_state();
    drive('0, '0);
    check_all("R4 reset zero", '0);
  endtask

  task automatic t_zero_sub();
    drive(W'(17'h1_2345), '0);
    check_all("R4 t zero", W'(17'h1_2345));
    drive({W{1'b1}}, '0);
    check_all("R4 p ones", {W{1'b1}});
  endtask

  task automatic t_full_borrow();
    drive('0, {1'b0, {WL{1'b1}}});
    check_all("R6 full ripple", W'((1 << W) - (1 << WL) + 1));
  endtask

  task automatic t_equal_low();
    drive(W'(17'h0_A5C3), {1'b0, 8'hC3});
    check_all("R8 equal low", W'(17'h0_A500));
  endtask

  task automatic t_top_bit_ignored();
    logic [W-1:0] first;
    drive(W'(17'h0_1234), {1'b0, 8'h56});
    first = s_sk;
    drive(W'(17'h0_1234), {1'b1, 8'h56});
    check("R5 t top bit", s_sk, first);
    check_all("R5 value", ref_diff(W'(17'h0_1234), 9'h056));
  endtask

  task automatic t_low_and_high();
    drive(W'(17'h1_0010), {1'b0, 8'h20});
    check("R2 low wrap", {9'h0, s_sk[WL-1:0]}, 17'h0_00F0);
    check("R3 high borrow", {8'h0, s_sk[W-1:WL]}, 17'h0_00FF);
    drive(W'(17'h1_0030), {1'b0, 8'h20});
    check("R3 high no borrow", {8'h0, s_sk[W-1:WL]}, 17'h0_0100);
  endtask

  task automatic t_random();
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] a;
      logic [WL:0]  b;
      a = W'($urandom);
      b = (WL+1)'($urandom);
      drive(a, b);
      check_all("R1 random", ref_diff(a, b));
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    p = '0;
    t = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_zero_sub();
    t_full_borrow();
    t_equal_low();
    t_top_bit_ignored();
    t_low_and_high();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule